// File: doc/BRIEF.md
# Programmable Interrupt Router Controller

This block gathers sixteen interrupt request lines and steers each one to one of eight CPU interrupt outputs. Every source owns a small control field that names its target output and switches it on or off. Five of the sources stand for PCI interrupt lines. Each of these five can be set to active-low or active-high, and to level or edge detection. The remaining eleven are fixed as active-high and level sensitive.

Software works through a synchronous 32-bit register port. It writes the routing words, the PCI line configuration and the per-output master enables. It reads a status halfword for each output, which lists the enabled sources routed there that are pending. It clears latched edge requests by writing a bit mask.

Raw inputs pass through a synchronizer before detection. Every CPU output is registered and active-high.

Top module: `irq_router`

## Requirements
- R1: After reset every routing word, the PCI configuration word, the output-enable word and every status word read as zero, and all irq_o bits are 0.
- R2: Source n owns bits [4*(n%8)+3 : 4*(n%8)] of the routing word at byte offset 0x00 (sources 0-7) or 0x04 (sources 8-15). Bits [2:0] of the field name the target output and bit 3 enables the source. A pending source appears only in the status of the output it names, and only while it is enabled.
- R3: The status word at offset 0x20+4*j carries the status of output 2*j in bits [15:0] and of output 2*j+1 in bits [31:16]. Bit n of a halfword is source n.
- R4: The output-enable word sits at offset 0x0C, and bit 16+k is the master enable of output k. irq_o[k] is 1 one cycle after the master enable is 1 and the status of output k is non-zero. It stays 0 while its master enable is 0. The other bits of this word read as zero.
- R5: The PCI configuration word sits at offset 0x08 and covers PCI lines i = 0..4 (sources 0..4). Bit 2*i set selects active-low input. Bit 2*i+1 set selects level detection, and clear selects edge detection. Bits 31:10 ignore writes and read as zero.
- R6: In edge mode, a transition of the polarity-corrected input from inactive to active sets the source's pending flag. The flag then holds until it is cleared, even after the input goes inactive.
- R7: In level mode, the pending flag follows the polarity-corrected input. A clear has no lasting effect while the line is still active.
- R8: The clear register sits at offset 0x10 and is write-only, reading as zero. A 1 in bit n clears edge-pending source n. A 0 bit leaves its source untouched. Several sources clear in one write.
- R9: Sources 5 to 15 act as active-high, level-detected inputs whatever the PCI configuration word holds.
- R10: Suppose a raw input changes just before a rising clock edge, with its source level-detected, enabled and routed. The status reflects the change after the third rising edge and not after the second. irq_o follows one edge later.
- R11: Writing zero to both routing words disables every source and routes every source to output 0. All status words then read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| src_i | input | 16 | Raw interrupt source lines, asynchronous |
| irq_o | output | 8 | Registered CPU interrupt outputs, active-high |

## Verification
The routing and gating logic is driven with random source levels, random routing words, random polarity and trigger settings, random master enables and random clear masks. Each state is compared against a settled reference model. The random mix tells a wrong route or a wrong enable bit apart from a wrong output gate, because each one shows in a different status halfword or output bit.

Directed cases then separate the two detection modes. A short pulse stays latched under edge detection and vanishes under level detection. A clear drops an edge flag but not an active level line. An active-low edge line shows that a polarity change alone can latch a request. A latency probe counts the synchronizer and pending stages. A multi-bit clear shows that zero bits in the mask spare their sources.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   // Byte offsets of the register map
   localparam int unsigned OFS_ROUTE = 'h00;
   localparam int unsigned OFS_PCFG  = 'h08;
   localparam int unsigned OFS_OEN   = 'h0C;
   localparam int unsigned OFS_CLR   = 'h10;
   localparam int unsigned OFS_STAT  = 'h20;

   // Per-line detection configuration for a configurable source
   typedef struct packed {
      logic level;   // 1: level detect, 0: edge detect
      logic inv;     // 1: active-low input
   } det_cfg_t;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic inv_i,
   input  logic level_i,
   input  logic clr_i,
   output logic pend_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_src_cell: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   corr;
   logic                   pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign corr = sync_q[SYNC_STAGES-1] ^ inv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= corr;
         if (level_i) pend_q <= corr;
         else         pend_q <= (pend_q & ~clr_i) | (corr & ~prev_q);
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
   import irq_router_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned NUM_OUT     = 8,
   parameter int unsigned NUM_CFG_SRC = 5,
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned OEN_LSB     = 16,
   localparam int unsigned CTRL_WORDS = (NUM_SRC * FIELD_W) / DATA_W,
   localparam int unsigned CFG_BITS   = 2 * NUM_CFG_SRC
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic [DATA_W-1:0]                    wdata,
   input  logic [NUM_OUT-1:0][NUM_SRC-1:0]      stat_i,
   output logic [DATA_W-1:0]                    rdata,
   output logic [CTRL_WORDS-1:0][DATA_W-1:0]    route_q,
   output logic [CFG_BITS-1:0]                  pcfg_q,
   output logic [NUM_OUT-1:0]                   oen_q,
   output logic [NUM_SRC-1:0]                   clr_o
);

   localparam int unsigned HALF_W     = DATA_W / 2;
   localparam int unsigned STAT_WORDS = NUM_OUT / 2;

   logic hit_pcfg, hit_oen, hit_clr;

   assign hit_pcfg = (addr == ADDR_W'(OFS_PCFG));
   assign hit_oen  = (addr == ADDR_W'(OFS_OEN));
   assign hit_clr  = (addr == ADDR_W'(OFS_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         pcfg_q  <= '0;
         oen_q   <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < CTRL_WORDS; w++) begin
            if (addr == ADDR_W'(OFS_ROUTE + 4 * w)) route_q[w] <= wdata;
         end
         if (hit_pcfg) pcfg_q <= wdata[CFG_BITS-1:0];
         if (hit_oen)  oen_q  <= wdata[OEN_LSB +: NUM_OUT];
      end
   end

   assign clr_o = (wr_en && hit_clr) ? wdata[NUM_SRC-1:0] : '0;

   always_comb begin
      rdata = '0;
      for (int w = 0; w < CTRL_WORDS; w++) begin
         if (addr == ADDR_W'(OFS_ROUTE + 4 * w)) rdata = route_q[w];
      end
      if (hit_pcfg) rdata[CFG_BITS-1:0] = pcfg_q;
      if (hit_oen)  rdata[OEN_LSB +: NUM_OUT] = oen_q;
      for (int j = 0; j < STAT_WORDS; j++) begin
         if (addr == ADDR_W'(OFS_STAT + 4 * j)) begin
            rdata[NUM_SRC-1:0]          = stat_i[2*j];
            rdata[HALF_W +: NUM_SRC]    = stat_i[2*j+1];
         end
      end
   end

endmodule

// File: rtl/irq_out_merge.sv
module irq_out_merge #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned NUM_OUT = 8,
   parameter int unsigned SEL_W   = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SRC-1:0]               pend_i,
   input  logic [NUM_SRC-1:0]               en_i,
   input  logic [NUM_SRC-1:0][SEL_W-1:0]    sel_i,
   input  logic [NUM_OUT-1:0]               oen_i,
   output logic [NUM_OUT-1:0][NUM_SRC-1:0]  stat_o,
   output logic [NUM_OUT-1:0]               irq_o
);

   logic [NUM_OUT-1:0] hit;

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         assign stat_o[k][n] = pend_i[n] & en_i[n] & (sel_i[n] == SEL_W'(k));
      end
      assign hit[k] = |stat_o[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= '0;
      else        irq_o <= hit & oen_i;
   end

endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned NUM_OUT     = 8,
   parameter int unsigned NUM_CFG_SRC = 5,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned OEN_LSB     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_OUT-1:0] irq_o
);

   localparam int unsigned FIELD_W    = SEL_W + 1;
   localparam int unsigned FPW        = DATA_W / FIELD_W;
   localparam int unsigned CTRL_WORDS = (NUM_SRC * FIELD_W) / DATA_W;
   localparam int unsigned CFG_BITS   = 2 * NUM_CFG_SRC;

   // Elaboration-time parameter checks
   if (NUM_OUT > (1 << SEL_W)) begin : g_chk_sel
      $error("irq_router: NUM_OUT exceeds the selector range");
   end
   if ((NUM_OUT % 2) != 0) begin : g_chk_even
      $error("irq_router: NUM_OUT must be even");
   end
   if (NUM_SRC > DATA_W / 2) begin : g_chk_half
      $error("irq_router: NUM_SRC must fit a status halfword");
   end
   if ((NUM_SRC * FIELD_W) % DATA_W != 0) begin : g_chk_words
      $error("irq_router: source fields must fill whole control words");
   end
   if (NUM_CFG_SRC > NUM_SRC || CFG_BITS > DATA_W) begin : g_chk_cfg
      $error("irq_router: too many configurable sources");
   end
   if (OEN_LSB + NUM_OUT > DATA_W) begin : g_chk_oen
      $error("irq_router: output enables do not fit the word");
   end

   logic [CTRL_WORDS-1:0][DATA_W-1:0]   route_q;
   logic [CFG_BITS-1:0]                 pcfg_q;
   logic [NUM_OUT-1:0]                  oen_q;
   logic [NUM_SRC-1:0]                  clr_mask;
   logic [NUM_SRC-1:0]                  pend;
   logic [NUM_SRC-1:0]                  lvl_mode;
   logic [NUM_SRC-1:0]                  inv_mode;
   logic [NUM_SRC-1:0]                  src_en;
   logic [NUM_SRC-1:0][SEL_W-1:0]       src_sel;
   logic [NUM_OUT-1:0][NUM_SRC-1:0]     stat;

   irq_router_regs #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .NUM_SRC     (NUM_SRC),
      .NUM_OUT     (NUM_OUT),
      .NUM_CFG_SRC (NUM_CFG_SRC),
      .FIELD_W     (FIELD_W),
      .OEN_LSB     (OEN_LSB)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .stat_i  (stat),
      .rdata   (rdata),
      .route_q (route_q),
      .pcfg_q  (pcfg_q),
      .oen_q   (oen_q),
      .clr_o   (clr_mask)
   );

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      localparam int unsigned WORD = n / FPW;
      localparam int unsigned POS  = (n % FPW) * FIELD_W;

      assign src_sel[n] = route_q[WORD][POS +: SEL_W];
      assign src_en[n]  = route_q[WORD][POS + SEL_W];

      if (n < NUM_CFG_SRC) begin : g_cfg
         det_cfg_t cfg;
         assign cfg         = det_cfg_t'(pcfg_q[2*n +: 2]);
         assign inv_mode[n] = cfg.inv;
         assign lvl_mode[n] = cfg.level;
      end else begin : g_fixed
         assign inv_mode[n] = 1'b0;
         assign lvl_mode[n] = 1'b1;
      end

      irq_src_cell #(
         .SYNC_STAGES (SYNC_STAGES)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .raw_i   (src_i[n]),
         .inv_i   (inv_mode[n]),
         .level_i (lvl_mode[n]),
         .clr_i   (clr_mask[n]),
         .pend_o  (pend[n])
      );
   end

   irq_out_merge #(
      .NUM_SRC (NUM_SRC),
      .NUM_OUT (NUM_OUT),
      .SEL_W   (SEL_W)
   ) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .en_i   (src_en),
      .sel_i  (src_sel),
      .oen_i  (oen_q),
      .stat_o (stat),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_router_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned NUM_OUT     = 8,
   parameter int unsigned NUM_CFG_SRC = 5,
   parameter int unsigned OEN_LSB     = 16
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [ADDR_W-1:0]               addr,
   input logic [DATA_W-1:0]               rdata,
   input logic [NUM_OUT-1:0]              irq_o,
   input logic [NUM_OUT-1:0]              oen,
   input logic [NUM_SRC-1:0]              pend,
   input logic [NUM_SRC-1:0]              lvl,
   input logic [NUM_SRC-1:0]              clr,
   input logic [NUM_OUT-1:0][NUM_SRC-1:0] stat
);

   logic [NUM_OUT-1:0] any_v;
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_any
      assign any_v[k] = |stat[k];
   end

   // R1: reset holds every output low
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (irq_o == '0));

   // R4: an output without its master enable stays low
   a_r4_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_o & ~$past(oen)) == '0));

   // R4: output follows gated status one cycle later
   a_r4_registered_or: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(oen & any_v)));

   // R6: an edge-latched flag survives unless cleared
   a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend & ~lvl & ~clr)) & ~lvl & ~pend) == '0));

   // R8: clear register reads as zero
   a_r8_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_CLR)) |-> (rdata == '0));

   // R5: unused configuration bits read as zero
   a_r5_cfg_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFS_PCFG)) |-> (rdata[DATA_W-1:2*NUM_CFG_SRC] == '0));

   // R2: a source shows in at most one output status
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
      logic [NUM_OUT-1:0] col;
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_bit
         assign col[k] = stat[k][n];
      end
      a_r2_single_route: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col));
   end

endmodule

bind irq_router irq_router_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .NUM_SRC     (NUM_SRC),
   .NUM_OUT     (NUM_OUT),
   .NUM_CFG_SRC (NUM_CFG_SRC),
   .OEN_LSB     (OEN_LSB)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (addr),
   .rdata (rdata),
   .irq_o (irq_o),
   .oen   (oen_q),
   .pend  (pend),
   .lvl   (lvl_mode),
   .clr   (clr_mask),
   .stat  (stat)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] raw = '0;
   logic [7:0]  irq_o;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   // reference model state
   logic [31:0] m_route [2];
   logic [9:0]  m_pcfg = '0;
   logic [7:0]  m_oen = '0;
   logic [15:0] m_pend = '0;
   logic [15:0] m_corr = '0;

   always #2.5 clk = ~clk;

   irq_router uut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .src_i (raw),
      .irq_o (irq_o)
   );

   function automatic logic is_level(int n);
      return (n < 5) ? m_pcfg[2*n+1] : 1'b1;
   endfunction

   function automatic logic [15:0] calc_corr();
      logic [15:0] c;
      for (int n = 0; n < 16; n++) c[n] = raw[n] ^ ((n < 5) ? m_pcfg[2*n] : 1'b0);
      return c;
   endfunction

   function automatic logic [15:0] exp_stat(int k);
      logic [15:0] s;
      for (int n = 0; n < 16; n++) begin
         logic [3:0] f;
         f = m_route[n/8][4*(n%8) +: 4];
         s[n] = m_pend[n] & f[3] & (f[2:0] == 3'(k));
      end
      return s;
   endfunction

   function automatic logic [7:0] exp_irq();
      logic [7:0] q;
      for (int k = 0; k < 8; k++) q[k] = m_oen[k] & (|exp_stat(k));
      return q;
   endfunction

   task automatic model_step();
      logic [15:0] nc;
      nc = calc_corr();
      for (int n = 0; n < 16; n++) begin
         if (is_level(n)) m_pend[n] = nc[n];
         else if (nc[n] && !m_corr[n]) m_pend[n] = 1'b1;
      end
      m_corr = nc;
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic do_write(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wr_route(int w, logic [31:0] d);
      m_route[w] = d;
      do_write(6'(4*w), d);
      settle();
   endtask

   task automatic wr_pcfg(logic [31:0] d);
      m_pcfg = d[9:0];
      do_write(6'h08, d);
      model_step();
      settle();
   endtask

   task automatic wr_oen(logic [31:0] d);
      m_oen = d[23:16];
      do_write(6'h0C, d);
      settle();
   endtask

   task automatic wr_clr(logic [15:0] mask);
      do_write(6'h10, {16'hA5A5, mask});
      for (int n = 0; n < 16; n++) if (mask[n] && !is_level(n)) m_pend[n] = 1'b0;
      settle();
   endtask

   task automatic set_raw(logic [15:0] v);
      @(negedge clk);
      raw = v;
      model_step();
      settle();
   endtask

   task automatic check_all(string tag);
      logic [31:0] d;
      for (int j = 0; j < 4; j++) begin
         do_read(6'(32 + 4*j), d);
         check({tag, " R3 status"}, d, {exp_stat(2*j+1), exp_stat(2*j)});
      end
      check({tag, " R4 irq"}, {24'h0, irq_o}, {24'h0, exp_irq()});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      m_route[0] = '0; m_route[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      do_read(6'h00, d); check("R1 route0", d, 0);
      do_read(6'h04, d); check("R1 route1", d, 0);
      do_read(6'h08, d); check("R1 pcfg", d, 0);
      do_read(6'h0C, d); check("R1 oen", d, 0);
      check_all("R1");

      // R2/R3/R4: source 7 to output 3
      wr_oen(32'h00FF_0000);
      wr_route(0, 32'hB000_0000);
      do_read(6'h00, d); check("R2 route readback", d, 32'hB000_0000);
      set_raw(16'h0080);
      do_read(6'h24, d); check("R3 out3 in word1 high half", d, 32'h0080_0000);
      check("R2 routed output", {24'h0, irq_o}, 32'h08);
      check_all("R2");

      // R4: master enable gating and reserved bits
      wr_oen(32'hFF00_FFFF);
      check("R4 gated low", {24'h0, irq_o}, 0);
      do_read(6'h0C, d); check("R4 reserved bits", d, 0);
      do_read(6'h24, d); check("R4 status kept", d, 32'h0080_0000);
      wr_oen(32'h00FF_0000);

      // R10: latency of source 7 (level)
      set_raw(16'h0000);
      addr = 6'h24;
      @(negedge clk);
      raw = 16'h0080;
      model_step();
      @(negedge clk); @(negedge clk);
      #1 check("R10 not after 2 edges", d & 0, rdata[23]);
      @(negedge clk);
      #1 check("R10 status after 3 edges", {31'h0, rdata[23]}, 1);
      check("R10 irq one edge later", {24'h0, irq_o}, 0);
      @(negedge clk);
      #1 check("R10 irq after 4 edges", {24'h0, irq_o}, 32'h08);
      set_raw(16'h0000);

      // R6/R8: PCI source 2 edge, route to output 1
      wr_route(0, 32'h0000_0900);
      set_raw(16'h0004);
      set_raw(16'h0000);
      do_read(6'h20, d); check("R6 edge latched", d, 32'h0004_0000);
      do_read(6'h10, d); check("R8 clear reads zero", d, 0);
      wr_clr(16'hFFFB);
      do_read(6'h20, d); check("R8 zero bit keeps", d, 32'h0004_0000);
      wr_clr(16'h0004);
      do_read(6'h20, d); check("R8 bit clears", d, 0);

      // R7: source 2 level mode
      wr_pcfg(32'h0000_0020);
      set_raw(16'h0004);
      wr_clr(16'h0004);
      do_read(6'h20, d); check("R7 level survives clear", d, 32'h0004_0000);
      set_raw(16'h0000);
      do_read(6'h20, d); check("R7 level follows input", d, 0);

      // R5: source 4 active-low edge; polarity flip latches
      wr_route(0, 32'h000A_0000);
      wr_pcfg(32'hFFFF_FD00);
      do_read(6'h08, d); check("R5 cfg readback", d, 32'h0000_0100);
      do_read(6'h24, d); check("R5 active-low latch", d, 32'h0000_0010);
      wr_clr(16'h0010);
      do_read(6'h24, d); check("R5 cleared", d, 0);
      wr_pcfg(32'h0);
      wr_clr(16'hFFFF);

      // R9: source 12 fixed level, routed to output 5
      wr_route(1, 32'h000D_0000);
      set_raw(16'h1000);
      wr_clr(16'h1000);
      do_read(6'h28, d); check("R9 level held through clear", d, 32'h1000_0000);
      wr_pcfg(32'h3FF);
      do_read(6'h28, d); check("R9 ignores cfg", d, 32'h1000_0000);
      wr_pcfg(32'h0);
      set_raw(16'h0000);

      // R8: multi-bit clear on sources 0,1,3
      wr_route(0, 32'h0000_A98F);
      set_raw(16'h000B);
      set_raw(16'h0000);
      check_all("R8 pre");
      wr_clr(16'h000A);
      check_all("R8 multi");

      // R11: zero routes
      wr_route(0, 32'h0);
      wr_route(1, 32'h0);
      do_read(6'h00, d); check("R11 route0 zero", d, 0);
      check_all("R11");
      wr_clr(16'hFFFF);

      // Random mix
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < 250; i++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0, 1, 2, 3: set_raw(16'($urandom));
            4:          wr_route(0, $urandom);
            5:          wr_route(1, $urandom);
            6:          wr_pcfg($urandom);
            7:          wr_oen($urandom);
            default:    wr_clr(16'($urandom));
         endcase
         check_all("R2 random");
      end

      finish_run();
   end

endmodule